// File: doc/BRIEF.md
# Rectangle Blit Address Walker with Clip Test

This block produces the memory address stream for a two-dimensional copy engine. A start strobe captures a source corner, a destination corner, the rectangle size, the screen pitch, the pixel depth, a vertical direction and a clip window. The block then presents one source address and one destination address per pixel. It moves left to right along each row and steps rows up or down. Each address is the sum of three terms: a 1 MiB segment base, the row coordinate times the pitch, and the column coordinate.

Each channel's segment base comes from two small control fields. A primary field overrides a fallback field whenever it is nonzero. The base is then divided by the bytes-per-pixel factor, so that it is counted in pixels. The destination coordinate of every pixel is tested against an inclusive clip window, and only the low 12 bits of each coordinate are compared. A pixel outside the window is still walked, but its write enable is low. The data path and the raster operations that consume these addresses sit outside this block.

Top module: `blit_addr_gen`

## Requirements
- R1: The source segment index is `segCtlA[5:4]` when the field `segCtlA[6:4]` is nonzero, and `segCtlB[3:2]` otherwise. So `segCtlA[6:4]=3'b100` selects index 0 from `segCtlA`.
- R2: The destination segment index is `segCtlA[1:0]` when `segCtlA[2:0]` is nonzero, and `segCtlB[1:0]` otherwise.
- R3: A segment base is the index times 0x100000. It is shifted right by 1 when `pixDepth`=1 (16-bit pixels), by 2 when `pixDepth`=2 (32-bit pixels), and not at all when `pixDepth`=0 or 3.
- R4: Each output address equals its own channel base, plus the row coordinate times `pitch`, plus the column coordinate, taken modulo 2^ADDR_W.
- R5: A start y is a 13-bit two's complement value with bit 12 as the sign. A negative row therefore gives an address below the base, wrapped modulo 2^ADDR_W.
- R6: When `dirDown`=1 both row coordinates increase by one per row. When `dirDown`=0 they decrease by one per row, wrapping in 13 bits.
- R7: Every row presents `width`+1 pixels. The x coordinates start at the latched start x and rise by one per accepted pixel, wrapping in 12 bits. Both x coordinates return to their start values on each new row.
- R8: The block walks `height`+1 rows. `busy` is high from the cycle after an accepted start through the last pixel. `done` is high for exactly one cycle, the cycle after the last pixel is accepted, with `busy` low.
- R9: `pixValid` is high on every walked pixel. `wrEn` is high only if the low 12 bits of the destination x lie in [`clipLeft`,`clipRight`] and the low 12 bits of the destination y lie in [`clipTop`,`clipBottom`], bounds inclusive. Clipped pixels still advance the walk.
- R10: While `stall` is high, the presented pixel, both addresses and `wrEn` hold, and no pixel is accepted.
- R11: A start while `busy` is ignored. Inputs are latched at the start, so changes to them during a walk do not alter the address stream or its length.
- R12: After reset, `busy`, `done`, `pixValid` and `wrEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk when idle |
| stall | input | 1 | Hold the presented pixel |
| segCtlA | input | 7 | Primary segment fields (source [6:4], destination [2:0]) |
| segCtlB | input | 4 | Fallback segment indices (source [3:2], destination [1:0]) |
| pixDepth | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit, 3: as 8-bit |
| srcX | input | CLIP_W | Source start column |
| srcY | input | CLIP_W+1 | Source start row, two's complement |
| dstX | input | CLIP_W | Destination start column |
| dstY | input | CLIP_W+1 | Destination start row, two's complement |
| width | input | CNT_W | Columns per row minus one |
| height | input | CNT_W | Rows minus one |
| pitch | input | PITCH_W | Row stride in address units |
| dirDown | input | 1 | 1: rows increase, 0: rows decrease |
| clipLeft | input | CLIP_W | Inclusive left clip bound |
| clipRight | input | CLIP_W | Inclusive right clip bound |
| clipTop | input | CLIP_W | Inclusive top clip bound |
| clipBottom | input | CLIP_W | Inclusive bottom clip bound |
| srcAddr | output | ADDR_W | Source pixel address |
| dstAddr | output | ADDR_W | Destination pixel address |
| pixValid | output | 1 | A pixel is presented |
| wrEn | output | 1 | Presented pixel lies inside the clip window |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |

## Verification
The bench uses the default widths: a 24-bit address, 12-bit coordinates and clip bounds, and 12-bit pitch and counts. At these widths the 7-bit primary field, the 4-bit fallback field and all four depth codes can be swept in full, one single-pixel walk per combination. Rectangles from 1x1 to 4x4 are walked in both vertical directions, with and without stalls. Their start coordinates sit where x wraps at 4095, where y crosses between 0 and -1, and where y is the most negative value. An exhaustive sweep of a small clip window around a 4x4 destination then reaches every edge of the inclusive comparison.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [1:0] {
    DEPTH8   = 2'd0,
    DEPTH16  = 2'd1,
    DEPTH32  = 2'd2,
    DEPTHRSV = 2'd3
  } pixDepth_t;

  typedef struct packed {
    logic load;
    logic colStep;
    logic rowStep;
  } blitStrobe_t;

endpackage

// File: rtl/blit_base_sel.sv
module blit_base_sel
  import blit_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SEG_LOG2 = 20
) (
  input  logic [6:0]        segCtlA,
  input  logic [3:0]        segCtlB,
  input  logic [1:0]        pixDepth,
  output logic [ADDR_W-1:0] srcBase,
  output logic [ADDR_W-1:0] dstBase
);

  logic [1:0] srcIdx;
  logic [1:0] dstIdx;

  function automatic logic [ADDR_W-1:0] scaledBase(input logic [1:0] idx, input logic [1:0] depth);
    logic [ADDR_W-1:0] raw;
    raw = ADDR_W'(idx) << SEG_LOG2;
    case (pixDepth_t'(depth))
      DEPTH16: return raw >> 1;
      DEPTH32: return raw >> 2;
      default: return raw;
    endcase
  endfunction

  always_comb begin
    srcIdx = (segCtlA[6:4] != 3'd0) ? segCtlA[5:4] : segCtlB[3:2];
    dstIdx = (segCtlA[2:0] != 3'd0) ? segCtlA[1:0] : segCtlB[1:0];
  end

  assign srcBase = scaledBase(srcIdx, pixDepth);
  assign dstBase = scaledBase(dstIdx, pixDepth);

endmodule

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        stall,
  input  logic        colLast,
  input  logic        rowLast,
  output blitStrobe_t strb,
  output logic        busy,
  output logic        done
);

  always_comb begin
    strb = '0;
    if (!busy && start) begin
      strb.load = 1'b1;
    end else if (busy && !stall) begin
      if (colLast) strb.rowStep = 1'b1;
      else         strb.colStep = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strb.load) begin
        busy <= 1'b1;
      end else if (strb.rowStep && rowLast) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R8
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(colLast && rowLast && !stall)) |=> (busy && !done));

endmodule

// File: rtl/blit_dpath.sv
module blit_dpath
  import blit_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int CLIP_W  = 12,
  parameter int PITCH_W = 12,
  parameter int CNT_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  blitStrobe_t         strb,
  input  logic                busy,
  input  logic                stall,
  input  logic [ADDR_W-1:0]   srcBaseIn,
  input  logic [ADDR_W-1:0]   dstBaseIn,
  input  logic [CLIP_W-1:0]   srcX,
  input  logic [CLIP_W:0]     srcY,
  input  logic [CLIP_W-1:0]   dstX,
  input  logic [CLIP_W:0]     dstY,
  input  logic [CNT_W-1:0]    width,
  input  logic [CNT_W-1:0]    height,
  input  logic [PITCH_W-1:0]  pitch,
  input  logic                dirDown,
  input  logic [CLIP_W-1:0]   clipLeft,
  input  logic [CLIP_W-1:0]   clipRight,
  input  logic [CLIP_W-1:0]   clipTop,
  input  logic [CLIP_W-1:0]   clipBottom,
  output logic                colLast,
  output logic                rowLast,
  output logic [ADDR_W-1:0]   srcAddr,
  output logic [ADDR_W-1:0]   dstAddr,
  output logic                pixValid,
  output logic                wrEn
);

  localparam int Y_W = CLIP_W + 1;
  localparam int NCH = 2;
  localparam logic [CLIP_W-1:0] X_ONE = CLIP_W'(1);
  localparam logic [Y_W-1:0]    Y_ONE = Y_W'(1);
  localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);

  function automatic logic [ADDR_W-1:0] rowAddr(input logic [ADDR_W-1:0] base,
                                                 input logic [Y_W-1:0]    y,
                                                 input logic [PITCH_W-1:0] p);
    logic [ADDR_W-1:0] yExt;
    logic [ADDR_W-1:0] pExt;
    yExt = {{(ADDR_W-Y_W){y[Y_W-1]}}, y};
    pExt = ADDR_W'(p);
    return base + yExt * pExt;
  endfunction

  logic [PITCH_W-1:0] pitchQ;
  logic               dirDownQ;
  logic [CNT_W-1:0]   widthQ;
  logic [CNT_W-1:0]   colLeft;
  logic [CNT_W-1:0]   rowLeft;
  logic [CLIP_W-1:0]  clipLQ, clipRQ, clipTQ, clipBQ;

  logic [CLIP_W-1:0]  xIn    [NCH];
  logic [Y_W-1:0]     yIn    [NCH];
  logic [ADDR_W-1:0]  baseIn [NCH];
  logic [CLIP_W-1:0]  curX   [NCH];
  logic [Y_W-1:0]     curY   [NCH];
  logic [ADDR_W-1:0]  addrOut[NCH];

  assign xIn[0]    = srcX;
  assign xIn[1]    = dstX;
  assign yIn[0]    = srcY;
  assign yIn[1]    = dstY;
  assign baseIn[0] = srcBaseIn;
  assign baseIn[1] = dstBaseIn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pitchQ   <= '0;
      dirDownQ <= 1'b0;
      widthQ   <= '0;
      colLeft  <= '0;
      rowLeft  <= '0;
      clipLQ   <= '0;
      clipRQ   <= '0;
      clipTQ   <= '0;
      clipBQ   <= '0;
    end else if (strb.load) begin
      pitchQ   <= pitch;
      dirDownQ <= dirDown;
      widthQ   <= width;
      colLeft  <= width;
      rowLeft  <= height;
      clipLQ   <= clipLeft;
      clipRQ   <= clipRight;
      clipTQ   <= clipTop;
      clipBQ   <= clipBottom;
    end else if (strb.rowStep) begin
      colLeft  <= widthQ;
      rowLeft  <= rowLeft - C_ONE;
    end else if (strb.colStep) begin
      colLeft  <= colLeft - C_ONE;
    end
  end

  assign colLast = (colLeft == '0);
  assign rowLast = (rowLeft == '0);

  for (genvar ch = 0; ch < NCH; ch++) begin : gChan
    logic [CLIP_W-1:0] x0Q;
    logic [CLIP_W-1:0] xQ;
    logic [Y_W-1:0]    yQ;
    logic [Y_W-1:0]    yNext;
    logic [ADDR_W-1:0] baseQ;
    logic [ADDR_W-1:0] rowQ;

    assign yNext = dirDownQ ? (yQ + Y_ONE) : (yQ - Y_ONE);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        x0Q   <= '0;
        xQ    <= '0;
        yQ    <= '0;
        baseQ <= '0;
        rowQ  <= '0;
      end else if (strb.load) begin
        x0Q   <= xIn[ch];
        xQ    <= xIn[ch];
        yQ    <= yIn[ch];
        baseQ <= baseIn[ch];
        rowQ  <= rowAddr(baseIn[ch], yIn[ch], pitch);
      end else if (strb.rowStep) begin
        xQ    <= x0Q;
        yQ    <= yNext;
        rowQ  <= rowAddr(baseQ, yNext, pitchQ);
      end else if (strb.colStep) begin
        xQ    <= xQ + X_ONE;
      end
    end

    assign curX[ch]    = xQ;
    assign curY[ch]    = yQ;
    assign addrOut[ch] = rowQ + ADDR_W'(xQ);
  end

  logic inClip;
  always_comb begin
    inClip = (curX[1] >= clipLQ) && (curX[1] <= clipRQ) &&
             (curY[1][CLIP_W-1:0] >= clipTQ) && (curY[1][CLIP_W-1:0] <= clipBQ);
  end

  assign srcAddr  = addrOut[0];
  assign dstAddr  = addrOut[1];
  assign pixValid = busy;
  assign wrEn     = busy && inClip;

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stall) |=> ($stable(srcAddr) && $stable(dstAddr) && $stable(wrEn)));

  // R7
  col_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.colStep |=> (curX[1] == CLIP_W'($past(curX[1]) + X_ONE)));

  // R6
  row_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rowStep && dirDownQ) |=> (curY[1] == Y_W'($past(curY[1]) + Y_ONE)));

  // R6
  row_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rowStep && !dirDownQ) |=> (curY[1] == Y_W'($past(curY[1]) - Y_ONE)));

endmodule

// File: rtl/blit_addr_gen.sv
module blit_addr_gen
  import blit_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SEG_LOG2 = 20,
  parameter int CLIP_W   = 12,
  parameter int PITCH_W  = 12,
  parameter int CNT_W    = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               stall,
  input  logic [6:0]         segCtlA,
  input  logic [3:0]         segCtlB,
  input  logic [1:0]         pixDepth,
  input  logic [CLIP_W-1:0]  srcX,
  input  logic [CLIP_W:0]    srcY,
  input  logic [CLIP_W-1:0]  dstX,
  input  logic [CLIP_W:0]    dstY,
  input  logic [CNT_W-1:0]   width,
  input  logic [CNT_W-1:0]   height,
  input  logic [PITCH_W-1:0] pitch,
  input  logic               dirDown,
  input  logic [CLIP_W-1:0]  clipLeft,
  input  logic [CLIP_W-1:0]  clipRight,
  input  logic [CLIP_W-1:0]  clipTop,
  input  logic [CLIP_W-1:0]  clipBottom,
  output logic [ADDR_W-1:0]  srcAddr,
  output logic [ADDR_W-1:0]  dstAddr,
  output logic               pixValid,
  output logic               wrEn,
  output logic               busy,
  output logic               done
);

  blitStrobe_t       strb;
  logic              colLast;
  logic              rowLast;
  logic [ADDR_W-1:0] srcBase;
  logic [ADDR_W-1:0] dstBase;

  blit_base_sel #(
    .ADDR_W  (ADDR_W),
    .SEG_LOG2(SEG_LOG2)
  ) i_baseSel (
    .segCtlA (segCtlA),
    .segCtlB (segCtlB),
    .pixDepth(pixDepth),
    .srcBase (srcBase),
    .dstBase (dstBase)
  );

  blit_ctrl i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .stall  (stall),
    .colLast(colLast),
    .rowLast(rowLast),
    .strb   (strb),
    .busy   (busy),
    .done   (done)
  );

  blit_dpath #(
    .ADDR_W (ADDR_W),
    .CLIP_W (CLIP_W),
    .PITCH_W(PITCH_W),
    .CNT_W  (CNT_W)
  ) i_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .busy      (busy),
    .stall     (stall),
    .srcBaseIn (srcBase),
    .dstBaseIn (dstBase),
    .srcX      (srcX),
    .srcY      (srcY),
    .dstX      (dstX),
    .dstY      (dstY),
    .width     (width),
    .height    (height),
    .pitch     (pitch),
    .dirDown   (dirDown),
    .clipLeft  (clipLeft),
    .clipRight (clipRight),
    .clipTop   (clipTop),
    .clipBottom(clipBottom),
    .colLast   (colLast),
    .rowLast   (rowLast),
    .srcAddr   (srcAddr),
    .dstAddr   (dstAddr),
    .pixValid  (pixValid),
    .wrEn      (wrEn)
  );

endmodule

// File: tb/test_blit_addr_gen.sv
module test_blit_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, stall;
  logic [6:0]  segCtlA;
  logic [3:0]  segCtlB;
  logic [1:0]  pixDepth;
  logic [11:0] srcX, dstX;
  logic [12:0] srcY, dstY;
  logic [11:0] width, height, pitch;
  logic        dirDown;
  logic [11:0] clipLeft, clipRight, clipTop, clipBottom;
  logic [23:0] srcAddr, dstAddr;
  logic        pixValid, wrEn, busy, done;

  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  blit_addr_gen i_blit_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .stall(stall),
    .segCtlA(segCtlA), .segCtlB(segCtlB), .pixDepth(pixDepth),
    .srcX(srcX), .srcY(srcY), .dstX(dstX), .dstY(dstY),
    .width(width), .height(height), .pitch(pitch), .dirDown(dirDown),
    .clipLeft(clipLeft), .clipRight(clipRight), .clipTop(clipTop), .clipBottom(clipBottom),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .pixValid(pixValid), .wrEn(wrEn),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expBase(input logic [6:0] a, input logic [3:0] b,
                                           input logic [1:0] d, input bit isSrc);
    int idx;
    int val;
    if (isSrc) idx = (a[6:4] != 0) ? int'(a[5:4]) : int'(b[3:2]);
    else       idx = (a[2:0] != 0) ? int'(a[1:0]) : int'(b[1:0]);
    val = idx * 1048576;
    if (d == 2'd1) val = val / 2;
    else if (d == 2'd2) val = val / 4;
    return val[23:0];
  endfunction

  function automatic logic [23:0] expAddr(input logic [23:0] base, input logic [12:0] y,
                                           input logic [11:0] p, input logic [11:0] x);
    longint yi;
    longint v;
    yi = (y[12]) ? longint'(y) - 8192 : longint'(y);
    v = longint'(base) + yi * longint'(p) + longint'(x);
    return v[23:0];
  endfunction

  task automatic runBlit(input string tag, input bit stallMode, input bit disturb);
    logic [23:0] bS, bD, eS, eD;
    logic [11:0] sx0, dx0, cl, cr, ct, cb, p, xs, xd;
    logic [12:0] sy0, dy0, ys, yd;
    int w, h;
    bit dn, eW;
    bS = expBase(segCtlA, segCtlB, pixDepth, 1'b1);
    bD = expBase(segCtlA, segCtlB, pixDepth, 1'b0);
    sx0 = srcX; dx0 = dstX; sy0 = srcY; dy0 = dstY; p = pitch; dn = dirDown;
    cl = clipLeft; cr = clipRight; ct = clipTop; cb = clipBottom;
    w = int'(width); h = int'(height);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int r = 0; r <= h; r++) begin
      ys = dn ? sy0 + 13'(r) : sy0 - 13'(r);
      yd = dn ? dy0 + 13'(r) : dy0 - 13'(r);
      for (int c = 0; c <= w; c++) begin
        xs = sx0 + 12'(c);
        xd = dx0 + 12'(c);
        eS = expAddr(bS, ys, p, xs);
        eD = expAddr(bD, yd, p, xd);
        eW = (xd >= cl) && (xd <= cr) && (yd[11:0] >= ct) && (yd[11:0] <= cb);
        if (stallMode && ((r + c) % 2 == 0)) begin
          stall = 1'b1;
          @(negedge clk);
          stall = 1'b0;
          chk("R10 held source address", 32'(srcAddr), 32'(eS));
          chk("R10 held destination address", 32'(dstAddr), 32'(eD));
          chk("R10 held write enable", 32'(wrEn), 32'(eW));
        end
        chk({tag, " source address"}, 32'(srcAddr), 32'(eS));
        chk({tag, " destination address"}, 32'(dstAddr), 32'(eD));
        chk("R9 clip write enable", 32'(wrEn), 32'(eW));
        chk("R9 pixel valid", 32'(pixValid), 32'd1);
        chk("R8 busy during walk", 32'(busy), 32'd1);
        if (disturb && r == 0 && c == 0) begin
          start = 1'b1;
          pitch = pitch ^ 12'h5a5;
          segCtlA = ~segCtlA;
          srcX = srcX + 12'd7;
          dstY = dstY + 13'd3;
          width = width + 12'd2;
          clipRight = 12'd0;
        end
        @(negedge clk);
        start = 1'b0;
      end
    end
    chk("R8 done pulse", 32'(done), 32'd1);
    chk("R8 busy low at done", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R8 done single cycle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; stall = 1'b0;
    segCtlA = '0; segCtlB = '0; pixDepth = '0;
    srcX = '0; dstX = '0; srcY = '0; dstY = '0;
    width = '0; height = '0; pitch = '0; dirDown = 1'b0;
    clipLeft = '0; clipRight = 12'hfff; clipTop = '0; clipBottom = 12'hfff;
    repeat (3) @(negedge clk);
    chk("R12 busy after reset", 32'(busy), 32'd0);
    chk("R12 done after reset", 32'(done), 32'd0);
    chk("R12 pixValid after reset", 32'(pixValid), 32'd0);
    chk("R12 wrEn after reset", 32'(wrEn), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3: full sweep of both segment fields and every depth code
    pitch = 12'd123;
    for (int a = 0; a < 128; a++)
      for (int b = 0; b < 16; b++)
        for (int d = 0; d < 4; d++) begin
          segCtlA = 7'(a); segCtlB = 4'(b); pixDepth = 2'(d);
          runBlit("R1 R2 R3", 1'b0, 1'b0);
        end

    // R4 R5 R6 R7 R11: rectangle walks across wrap and sign boundaries
    segCtlA = 7'h21; segCtlB = 4'h0; pixDepth = 2'd1;
    for (int w = 0; w < 4; w++)
      for (int h = 0; h < 4; h++)
        for (int dn = 0; dn < 2; dn++)
          for (int st = 0; st < 2; st++) begin
            segCtlA = 7'h21;
            width = 12'(w); height = 12'(h); dirDown = dn[0];
            pitch = 12'd640 + 12'(w);
            srcX = 12'hffe; dstX = 12'(w * 5);
            srcY = (h % 2 == 0) ? 13'h1000 : 13'h0ffe;
            dstY = dn[0] ? 13'h1ffe : 13'h0001;
            clipLeft = 12'd2; clipRight = 12'd9; clipTop = 12'd0; clipBottom = 12'd1;
            if (st == 0 && ((w + h) % 3 == 0))
              runBlit("R11 latched", 1'b0, 1'b1);
            else
              runBlit("R4 R5 R6 R7", st[0], 1'b0);
          end

    // R9: exhaustive small clip window around a 4x4 destination
    segCtlA = 7'h00; segCtlB = 4'h6; pixDepth = 2'd0;
    width = 12'd3; height = 12'd3; dirDown = 1'b1; pitch = 12'd16;
    srcX = 12'd1; srcY = 13'd2; dstX = 12'd4; dstY = 13'd4;
    for (int l = 3; l < 9; l++)
      for (int rr = 3; rr < 9; rr++)
        for (int t = 3; t < 9; t++)
          for (int bt = 3; bt < 9; bt++) begin
            clipLeft = 12'(l); clipRight = 12'(rr); clipTop = 12'(t); clipBottom = 12'(bt);
            runBlit("R9 R4", 1'b0, 1'b0);
          end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule